// File: doc/BRIEF.md
# Protocol Discovery Responder and Walker

This block handles protocol discovery over a data-object mailbox. Discovery runs under vendor ID 0x0001 and object type 0. The block has two independent halves.

The responder half answers discovery requests from a fixed, parameterized list of supported protocols. Each reply carries three things:
- the vendor ID found at the requested position;
- the protocol type found at that position;
- the position of the following entry, or 0 after the last entry.

The requester half is a walker. On a start pulse it first resets the mailbox by issuing an abort. It then sends discovery requests over an abstract request/response port, beginning at position 0. Each reply supplies the position used in the next request. The walk ends when a reply carries a next position of 0.

Every reply the walker accepts is written into a small cache. The cache answers a combinational "is this protocol supported" lookup. The discovery protocol itself always reads as supported, whether or not a walk has run.

A failed exchange ends the walk with a failure indication. So do a malformed reply and a full cache.

Top module: `proto_disc`

## Requirements
- R1: One cycle after `respReqValid`, `respRspValid` is high. For an in-range index (bits [7:0] of the request), `respRspDword` holds vendor ID in [15:0], type in [23:16] and next index in [31:24]. The next index is index+1, or 0 for the last list entry.
- R2: For an index at or beyond the list size, the responder replies with list entry 0 and next index 0.
- R3: After `start`, the walker holds `xAbort` high until `xAbortDone`, and issues no request before that. The first request follows in the cycle after `xAbortDone`.
- R4: Each request is a one-cycle `xReqValid` pulse. The index sits in [7:0] of `xReqDword` and bits [31:8] are zero. The first index is 0, and each later index is the next index of the previous reply.
- R5: A valid reply whose next index is 0 ends the walk with `walkOk` high and `walkBusy` low. Each valid reply stores exactly one entry.
- R6: `lookupHit` is high for a (vendor, type) pair stored by the last walk, and low for any other pair except discovery.
- R7: A lookup of vendor 0x0001 with type 0 always hits, including after reset with no walk.
- R8: A reply with `xRspErr` high, or with `xRspLen` other than 1, ends the walk with `walkFail` high and no further requests.
- R9: A valid reply that arrives while the cache holds CACHE_DEPTH entries ends the walk with `walkFail`. That reply is not stored.
- R10: `start` clears the cache and both outcome flags before the new walk begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| walkBusy | output | 1 | Walk in progress |
| walkOk | output | 1 | Last walk finished normally |
| walkFail | output | 1 | Last walk failed |
| xAbort | output | 1 | Mailbox abort request |
| xAbortDone | input | 1 | Mailbox abort completed |
| xReqValid | output | 1 | Discovery request strobe |
| xReqDword | output | 32 | Request payload (index in [7:0]) |
| xRspValid | input | 1 | Reply strobe |
| xRspDword | input | 32 | Reply payload |
| xRspLen | input | LEN_W | Reply payload length in dwords |
| xRspErr | input | 1 | Exchange error on this reply |
| lookupVid | input | 16 | Vendor ID to look up |
| lookupType | input | 8 | Protocol type to look up |
| lookupHit | output | 1 | Pair is supported |
| respReqValid | input | 1 | Incoming discovery request strobe |
| respReqDword | input | 32 | Incoming request payload |
| respRspValid | output | 1 | Responder reply strobe |
| respRspDword | output | 32 | Responder reply payload |

## Verification
The bench builds the block with a four-entry protocol list and CACHE_DEPTH of 4. With these values, a full walk through the responder fills the cache exactly, which exercises the boundary where the last entry still fits.

A synthetic reply chain whose next index never returns to 0 drives a fifth reply into the full cache, which brings the overflow failure within reach.

Indices 7 and 255 exercise the out-of-range reply. Error and length faults are injected at chosen reply positions, so aborted walks and the cache clearing on restart are both covered.

// File: rtl/proto_disc_pkg.sv
package proto_disc_pkg;
  localparam logic [15:0] DISC_VID  = 16'h0001;
  localparam logic [7:0]  DISC_TYPE = 8'h00;
  localparam int IDX_W   = 8;
  localparam int ENTRY_W = 24;   // {type, vid}

  typedef struct packed {
    logic clearCache;
    logic storeEntry;
    logic loadIdx;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    W_IDLE, W_ABORT, W_SEND, W_WAIT
  } walkState_t;
endpackage

// File: rtl/disc_responder.sv
module disc_responder
  import proto_disc_pkg::*;
#(
  parameter int NUM_PROTO = 4,
  parameter logic [NUM_PROTO*ENTRY_W-1:0] PROTO_LIST = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [31:0] reqDword,
  output logic        rspValid,
  output logic [31:0] rspDword
);
  logic [IDX_W-1:0]   idx;
  logic               inRange;
  logic [IDX_W-1:0]   nextIdx;
  logic [ENTRY_W-1:0] entry;

  assign idx     = reqDword[IDX_W-1:0];
  assign inRange = (32'(idx) < NUM_PROTO);
  assign nextIdx = (inRange && (32'(idx) + 1 < NUM_PROTO)) ? idx + 8'd1 : 8'd0;

  always_comb begin
    entry = PROTO_LIST[ENTRY_W-1:0];
    for (int i = 0; i < NUM_PROTO; i++) begin
      if (inRange && (32'(idx) == i)) entry = PROTO_LIST[i*ENTRY_W +: ENTRY_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspDword <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) rspDword <= {nextIdx, entry};
    end
  end
endmodule

// File: rtl/disc_dpath.sv
module disc_dpath
  import proto_disc_pkg::*;
#(
  parameter int CACHE_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strobe,
  input  logic [31:0] rspDword,
  input  logic [15:0] lookupVid,
  input  logic [7:0]  lookupType,
  output logic [31:0] reqDword,
  output logic        cacheFull,
  output logic        lookupHit
);
  localparam int CNT_W = $clog2(CACHE_DEPTH + 1);

  logic [CNT_W-1:0]   fillCnt;
  logic [IDX_W-1:0]   curIdx;
  logic [ENTRY_W-1:0] cacheMem [CACHE_DEPTH];
  logic [CACHE_DEPTH-1:0] match;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
      curIdx  <= '0;
    end else if (strobe.clearCache) begin
      fillCnt <= '0;
      curIdx  <= '0;
    end else begin
      if (strobe.storeEntry) fillCnt <= fillCnt + 1'b1;
      if (strobe.loadIdx)    curIdx  <= rspDword[31:24];
    end
  end

  for (genvar g = 0; g < CACHE_DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) cacheMem[g] <= '0;
      else if (strobe.storeEntry && !strobe.clearCache && fillCnt == CNT_W'(g))
        cacheMem[g] <= rspDword[ENTRY_W-1:0];
    end
    assign match[g] = (CNT_W'(g) < fillCnt) && (cacheMem[g] == {lookupType, lookupVid});
  end

  assign cacheFull = (fillCnt == CNT_W'(CACHE_DEPTH));
  assign reqDword  = {{(32-IDX_W){1'b0}}, curIdx};
  assign lookupHit = (|match) || (lookupVid == DISC_VID && lookupType == DISC_TYPE);
endmodule

// File: rtl/disc_ctrl.sv
module disc_ctrl
  import proto_disc_pkg::*;
#(
  parameter int LEN_W = 19
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             xAbortDone,
  input  logic             xRspValid,
  input  logic [LEN_W-1:0] xRspLen,
  input  logic             xRspErr,
  input  logic [IDX_W-1:0] rspNext,
  input  logic             cacheFull,
  output dpStrobe_t        strobe,
  output logic             xAbort,
  output logic             xReqValid,
  output logic             walkBusy,
  output logic             walkOk,
  output logic             walkFail
);
  walkState_t state, nextState;
  logic badRsp, endOk, endFail;

  assign badRsp = xRspErr || (xRspLen != LEN_W'(1));

  always_comb begin
    nextState = state;
    strobe    = '0;
    endOk     = 1'b0;
    endFail   = 1'b0;
    case (state)
      W_IDLE: if (start) begin
        strobe.clearCache = 1'b1;
        nextState = W_ABORT;
      end
      W_ABORT: if (xAbortDone) nextState = W_SEND;
      W_SEND:  nextState = W_WAIT;
      W_WAIT: if (xRspValid) begin
        if (badRsp || cacheFull) begin
          endFail   = 1'b1;
          nextState = W_IDLE;
        end else begin
          strobe.storeEntry = 1'b1;
          strobe.loadIdx    = 1'b1;
          if (rspNext == '0) begin
            endOk     = 1'b1;
            nextState = W_IDLE;
          end else begin
            nextState = W_SEND;
          end
        end
      end
      default: nextState = W_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= W_IDLE;
      walkOk   <= 1'b0;
      walkFail <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.clearCache) begin
        walkOk   <= 1'b0;
        walkFail <= 1'b0;
      end
      if (endOk)   walkOk   <= 1'b1;
      if (endFail) walkFail <= 1'b1;
    end
  end

  assign xAbort    = (state == W_ABORT);
  assign xReqValid = (state == W_SEND);
  assign walkBusy  = (state != W_IDLE);
endmodule

// File: rtl/proto_disc.sv
module proto_disc
  import proto_disc_pkg::*;
#(
  parameter int NUM_PROTO   = 4,
  parameter int CACHE_DEPTH = 4,
  parameter int LEN_W       = 19,
  parameter logic [NUM_PROTO*ENTRY_W-1:0] PROTO_LIST =
    {24'h55_1234, 24'h01_0001, 24'h02_1E98, 24'h00_0001}
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output logic             walkBusy,
  output logic             walkOk,
  output logic             walkFail,
  output logic             xAbort,
  input  logic             xAbortDone,
  output logic             xReqValid,
  output logic [31:0]      xReqDword,
  input  logic             xRspValid,
  input  logic [31:0]      xRspDword,
  input  logic [LEN_W-1:0] xRspLen,
  input  logic             xRspErr,
  input  logic [15:0]      lookupVid,
  input  logic [7:0]       lookupType,
  output logic             lookupHit,
  input  logic             respReqValid,
  input  logic [31:0]      respReqDword,
  output logic             respRspValid,
  output logic [31:0]      respRspDword
);
  dpStrobe_t strobe;
  logic      cacheFull;

  disc_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .xAbortDone(xAbortDone),
    .xRspValid(xRspValid), .xRspLen(xRspLen), .xRspErr(xRspErr),
    .rspNext(xRspDword[31:24]), .cacheFull(cacheFull), .strobe(strobe),
    .xAbort(xAbort), .xReqValid(xReqValid), .walkBusy(walkBusy),
    .walkOk(walkOk), .walkFail(walkFail)
  );

  disc_dpath #(.CACHE_DEPTH(CACHE_DEPTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rspDword(xRspDword),
    .lookupVid(lookupVid), .lookupType(lookupType), .reqDword(xReqDword),
    .cacheFull(cacheFull), .lookupHit(lookupHit)
  );

  disc_responder #(.NUM_PROTO(NUM_PROTO), .PROTO_LIST(PROTO_LIST)) u_resp (
    .clk(clk), .rstN(rstN), .reqValid(respReqValid), .reqDword(respReqDword),
    .rspValid(respRspValid), .rspDword(respRspDword)
  );
endmodule

// File: rtl/proto_disc_checker.sv
module proto_disc_checker
  import proto_disc_pkg::*;
#(
  parameter int NUM_PROTO = 4,
  parameter logic [NUM_PROTO*ENTRY_W-1:0] PROTO_LIST = '0
) (
  input logic        clk,
  input logic        rstN,
  input logic        walkBusy,
  input logic        walkOk,
  input logic        walkFail,
  input logic        xAbort,
  input logic        xAbortDone,
  input logic        xReqValid,
  input logic [31:0] xReqDword,
  input logic [15:0] lookupVid,
  input logic [7:0]  lookupType,
  input logic        lookupHit,
  input logic        respReqValid,
  input logic [31:0] respReqDword,
  input logic        respRspValid,
  input logic [31:0] respRspDword
);
  a_r1_reply_follows: assert property (@(posedge clk) disable iff (!rstN)
    respReqValid |=> respRspValid);
  a_r1_no_spurious_reply: assert property (@(posedge clk) disable iff (!rstN)
    !respReqValid |=> !respRspValid);
  a_r2_oor_entry0: assert property (@(posedge clk) disable iff (!rstN)
    (respReqValid && (32'(respReqDword[7:0]) >= NUM_PROTO))
      |=> (respRspDword == {8'd0, PROTO_LIST[ENTRY_W-1:0]}));
  a_r3_req_after_abort: assert property (@(posedge clk) disable iff (!rstN)
    (xAbort && xAbortDone) |=> xReqValid);
  a_r4_req_pulse: assert property (@(posedge clk) disable iff (!rstN)
    xReqValid |=> !xReqValid);
  a_r4_req_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    xReqValid |-> (xReqDword[31:8] == 24'd0));
  a_r5_outcome_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(walkOk && walkFail));
  a_r7_disc_hit: assert property (@(posedge clk) disable iff (!rstN)
    (lookupVid == DISC_VID && lookupType == DISC_TYPE) |-> lookupHit);
  a_r8_fail_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (walkFail && !walkBusy) |-> !xReqValid);
endmodule

bind proto_disc proto_disc_checker #(.NUM_PROTO(NUM_PROTO), .PROTO_LIST(PROTO_LIST)) u_chk (
  .clk(clk), .rstN(rstN), .walkBusy(walkBusy), .walkOk(walkOk), .walkFail(walkFail),
  .xAbort(xAbort), .xAbortDone(xAbortDone), .xReqValid(xReqValid), .xReqDword(xReqDword),
  .lookupVid(lookupVid), .lookupType(lookupType), .lookupHit(lookupHit),
  .respReqValid(respReqValid), .respReqDword(respReqDword),
  .respRspValid(respRspValid), .respRspDword(respRspDword)
);

// File: tb/sim_proto_disc.sv
module sim_proto_disc;
  localparam int LEN_W = 19;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic walkBusy, walkOk, walkFail, xAbort, xReqValid, lookupHit, respRspValid;
  logic xAbortDone = 1'b0, xRspValid = 1'b0, xRspErr = 1'b0;
  logic [31:0] xReqDword, respRspDword;
  logic [31:0] xRspDword = '0;
  logic [LEN_W-1:0] xRspLen = LEN_W'(1);
  logic [15:0] lookupVid = '0;
  logic [7:0]  lookupType = '0;
  logic dirValid = 1'b0, trValid = 1'b0;
  logic [31:0] dirDword = '0, trDword = '0;
  logic respReqValid;
  logic [31:0] respReqDword;

  assign respReqValid = dirValid | trValid;
  assign respReqDword = dirValid ? dirDword : trDword;

  always #5 clk = ~clk;

  proto_disc #(.NUM_PROTO(4), .CACHE_DEPTH(4), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .walkBusy(walkBusy), .walkOk(walkOk),
    .walkFail(walkFail), .xAbort(xAbort), .xAbortDone(xAbortDone),
    .xReqValid(xReqValid), .xReqDword(xReqDword), .xRspValid(xRspValid),
    .xRspDword(xRspDword), .xRspLen(xRspLen), .xRspErr(xRspErr),
    .lookupVid(lookupVid), .lookupType(lookupType), .lookupHit(lookupHit),
    .respReqValid(respReqValid), .respReqDword(respReqDword),
    .respRspValid(respRspValid), .respRspDword(respRspDword)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] reqQ [$];
  logic [31:0] rspQ [$];
  int fakeMode = 0, errAt = -1, lenAt = -1, respCount = 0, abortCnt = 0;
  bit abortSeen = 0, pend = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Independent model of the responder list
  function automatic logic [31:0] expRsp(input int idx);
    logic [15:0] vids [4] = '{16'h0001, 16'h1E98, 16'h0001, 16'h1234};
    logic [7:0]  typs [4] = '{8'h00, 8'h02, 8'h01, 8'h55};
    if (idx >= 4) return {8'd0, typs[0], vids[0]};
    return {(idx < 3) ? 8'(idx + 1) : 8'd0, typs[idx], vids[idx]};
  endfunction

  // Transport model and request monitor
  initial begin
    forever begin
      @(negedge clk);
      if (xAbort) abortCnt++; else abortCnt = 0;
      xAbortDone = xAbort && (abortCnt >= 3);
      xRspValid = 1'b0; xRspErr = 1'b0; xRspLen = LEN_W'(1); trValid = 1'b0;
      if (pend) begin
        pend = 0;
        xRspValid = 1'b1;
        xRspDword = fakeMode ? {8'd1, 8'(respCount), 16'h00A0} : respRspDword;
        xRspErr   = (respCount == errAt);
        xRspLen   = (respCount == lenAt) ? LEN_W'(2) : LEN_W'(1);
        respCount++;
      end
      if (xReqValid) begin
        check(abortSeen, "R3 request before abort", 32'(abortSeen), 32'd1);
        if (reqQ.size() == 0) check(1'b0, "R8 unexpected request", xReqDword, 32'hFFFFFFFF);
        else begin
          logic [31:0] e;
          e = reqQ.pop_front();
          check(xReqDword == e, "R4 request index", xReqDword, e);
        end
        if (!fakeMode) begin
          trValid = 1'b1; trDword = xReqDword;
          rspQ.push_back(expRsp(int'(xReqDword[7:0])));
        end
        pend = 1;
      end
      if (xAbort) abortSeen = 1;
    end
  end

  // Responder monitor
  initial begin
    forever begin
      @(negedge clk);
      if (respRspValid) begin
        if (rspQ.size() == 0) check(1'b0, "R1 unexpected reply", respRspDword, 32'hFFFFFFFF);
        else begin
          logic [31:0] e;
          e = rspQ.pop_front();
          check(respRspDword == e, "R1 R2 reply word", respRspDword, e);
        end
      end
    end
  end

  task automatic dirReq(input int idx);
    @(negedge clk);
    dirValid = 1'b1; dirDword = 32'(idx) | 32'hABCD0000;
    rspQ.push_back(expRsp(idx));
    @(negedge clk);
    dirValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic runWalk();
    abortSeen = 0; respCount = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (walkBusy) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic look(input logic [15:0] v, input logic [7:0] t, input bit exp, input string req);
    @(negedge clk);
    lookupVid = v; lookupType = t;
    #1;
    check(lookupHit == exp, req, 32'(lookupHit), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!walkBusy && !walkOk && !walkFail, "R5 reset outcome", {walkBusy, walkOk, walkFail}, 0);
    check(!xReqValid && !xAbort && !respRspValid, "R3 reset idle", {xReqValid, xAbort, respRspValid}, 0);
    look(16'h0001, 8'h00, 1, "R7 discovery before walk");
    look(16'h1E98, 8'h02, 0, "R6 miss before walk");

    for (int i = 0; i < 4; i++) dirReq(i);   // R1
    dirReq(7);                                // R2
    dirReq(255);                              // R2

    // Full walk: fills the cache exactly (R5, R9 boundary)
    reqQ = '{32'd0, 32'd1, 32'd2, 32'd3};
    runWalk();
    check(walkOk && !walkFail, "R5 walk ok", {walkOk, walkFail}, 2'b10);
    check(reqQ.size() == 0, "R4 all requests issued", reqQ.size(), 0);
    look(16'h1E98, 8'h02, 1, "R6 hit entry1");
    look(16'h0001, 8'h01, 1, "R6 hit entry2");
    look(16'h1234, 8'h55, 1, "R6 hit entry3");
    look(16'h1234, 8'h54, 0, "R6 miss type");
    look(16'h1E98, 8'h03, 0, "R6 miss type2");

    // Error injected at reply 1 (R8, R10)
    errAt = 1;
    reqQ = '{32'd0, 32'd1};
    runWalk();
    errAt = -1;
    check(walkFail && !walkOk, "R8 error fails walk", {walkOk, walkFail}, 2'b01);
    check(reqQ.size() == 0, "R8 requests issued", reqQ.size(), 0);
    look(16'h0001, 8'h01, 0, "R10 cache cleared");
    look(16'h0001, 8'h00, 1, "R7 discovery after fail");

    // Bad length on first reply (R8)
    lenAt = 0;
    reqQ = '{32'd0};
    runWalk();
    lenAt = -1;
    check(walkFail && !walkOk, "R8 length fails walk", {walkOk, walkFail}, 2'b01);
    look(16'h0001, 8'h00, 1, "R7 discovery empty cache");

    // Endless chain overflows the cache (R9)
    fakeMode = 1;
    reqQ = '{32'd0, 32'd1, 32'd1, 32'd1, 32'd1};
    runWalk();
    fakeMode = 0;
    check(walkFail && !walkOk, "R9 overflow fails walk", {walkOk, walkFail}, 2'b01);
    check(reqQ.size() == 0, "R9 five requests", reqQ.size(), 0);
    look(16'h00A0, 8'h03, 1, "R9 fourth reply stored");
    look(16'h00A0, 8'h04, 0, "R9 fifth reply dropped");

    // Restart clears everything and walks again (R10)
    reqQ = '{32'd0, 32'd1, 32'd2, 32'd3};
    runWalk();
    check(walkOk && !walkFail, "R10 restart ok", {walkOk, walkFail}, 2'b10);
    look(16'h00A0, 8'h00, 0, "R10 old entries gone");
    look(16'h1234, 8'h55, 1, "R6 hit after restart");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule